// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold and Trailing-Data Interrupts

This block holds two byte queues between a register bus and a serial engine. The transmit queue is filled by the bus and drained by the engine. The receive queue is filled by the engine and drained by the bus. Each queue has its own enable and trigger level. One packed status word reports both fill levels together with their full and empty flags. Reads from either queue are show-ahead: the head byte is on the data output before the pop strobe.

An interrupt status word collects these events:
- transmit almost-empty and receive almost-full;
- overrun and underrun on both queues;
- a trailing-data timeout;
- a transfer-complete pulse from the engine.

Software clears status bits by writing ones to them. An enable mask selects which bits drive the single interrupt line. The trailing timer catches a short tail of received bytes that never reaches the receive trigger. It fires after a programmable run of idle cycles while received data is waiting.

Top module: `dual_byte_fifo_irq`

## Requirements
- R1: While reset is asserted, both queues read empty. `fifoStat` is 32'h0100_0100, `intStat` is 0 and `irq` is 0. The trailing field resets to 15 and every other setting resets to 0.
- R2: Bytes leave each queue in the order they entered. `fifoStat` packs these fields:
  - transmit: level in bits 6:0, full at bit 7, empty at bit 8;
  - receive: level in bits 22:16, full at bit 23, empty at bit 24.
  Each queue holds `DEPTH` bytes.
- R3: A push into a full queue with no accepted pop in the same cycle drops the byte. It sets transmit overrun (status bit 3) or receive overrun (status bit 5).
- R4: A pop from an empty queue returns 0 on the data output. It sets transmit underrun (bit 2) or receive underrun (bit 4).
- R5: Status bit 0 is set on every clock edge at which the transmit level is at or below the transmit trigger. The transmit trigger is `ctrlWdata[22:16]`.
- R6: Status bit 1 is set on every clock edge at which the receive level is at or above the receive trigger. The receive trigger is `ctrlWdata[10:4]`.
- R7: Status bit 6 is set on the N-th consecutive idle edge, where N is the trailing field plus 1. An idle edge is one where the receive queue is non-empty and no receive push or pop strobe is present. Any receive push or pop, or an empty queue, restarts the count. The timer fires once per idle run.
- R8: Writing `intClrWr` clears every status bit that has a 1 in `intClrWdata`. All other bits keep their value. A new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit is 1 and its mask bit is also 1. The mask is written through `intEnWdata`, using the same bit positions as the status word.
- R10: Receive is enabled by `ctrlWdata[0]` and transmit by `ctrlWdata[1]`. A disabled queue is emptied. Its push and pop strobes have no effect and raise no overrun or underrun.
- R11: A `xferDone` pulse sets status bit 9.
- R12: A push and a pop on a full queue in the same cycle are both accepted. The level stays at `DEPTH` and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Write strobe for the control word |
| ctrlWdata | input | 32 | Control word: enables and trigger levels |
| intEnWr | input | 1 | Write strobe for the interrupt enable mask |
| intEnWdata | input | 32 | New interrupt enable mask |
| intClrWr | input | 1 | Write-one-to-clear strobe for interrupt status |
| intClrWdata | input | 32 | Bits of the interrupt status to clear |
| trailWr | input | 1 | Write strobe for the trailing count field |
| trailWdata | input | 4 | Trailing count field |
| busTxPush | input | 1 | Bus pushes a byte into the transmit queue |
| busTxData | input | 8 | Byte pushed into the transmit queue |
| busRxPop | input | 1 | Bus pops the receive queue |
| busRxData | output | 8 | Head of the receive queue, 0 when empty |
| engTxPop | input | 1 | Engine pops the transmit queue |
| engTxData | output | 8 | Head of the transmit queue, 0 when empty |
| engRxPush | input | 1 | Engine pushes a byte into the receive queue |
| engRxData | input | 8 | Byte pushed into the receive queue |
| xferDone | input | 1 | Transfer-complete event from the engine |
| fifoStat | output | 32 | Packed levels and flags of both queues |
| intStat | output | 32 | Interrupt status word |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check, on every cycle, that no level exceeds the depth and that a push blocked by a full queue leaves the level unchanged. They also check that an underrun pop presents zero, and that the overrun, underrun and trailing bits only rise after the matching full, empty or non-empty condition. Only the bench scenarios can show the rest, by comparison with the reference queue model:
- byte ordering through both queues;
- the exact edge on which the trailing timer fires;
- selective write-one-to-clear behaviour, including a new event winning over the clear;
- mask gating of the interrupt line;
- queue disabling;
- acceptance of a push and a pop together on a full queue.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int STAT_W   = 32;
  localparam int TRIG_W   = 7;
  localparam int TRAIL_W  = 4;

  localparam int CTRL_RX_EN      = 0;
  localparam int CTRL_TX_EN      = 1;
  localparam int CTRL_RX_TRIG_LO = 4;
  localparam int CTRL_TX_TRIG_LO = 16;

  localparam int IRQ_TX_AE   = 0;
  localparam int IRQ_RX_AF   = 1;
  localparam int IRQ_TX_UND  = 2;
  localparam int IRQ_TX_OVR  = 3;
  localparam int IRQ_RX_UND  = 4;
  localparam int IRQ_RX_OVR  = 5;
  localparam int IRQ_TRAIL   = 6;
  localparam int IRQ_XFER    = 9;

  localparam logic [STAT_W-1:0] IRQ_VALID = 32'h0000_027F;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifo_strobe_t;

  typedef struct packed {
    logic txFull;
    logic txEmpty;
    logic txOvr;
    logic txUnd;
    logic rxFull;
    logic rxEmpty;
    logic rxOvr;
    logic rxUnd;
  } fifo_flags_t;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             overrun,
  output logic             underrun
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             popOk, pushOk;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign popOk    = pop && !empty;
  assign pushOk   = push && (!full || popOk);
  assign overrun  = push && full && !popOk;
  assign underrun = pop && empty;
  assign rdata    = empty ? 8'h00 : mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      if (pushOk && !popOk)      level <= level + 1'b1;
      else if (popOk && !pushOk) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= wdata;
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> (level == $past(level)));

  assert_underrun_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (rdata == 8'h00));

endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_strobe_t     strobe,
  input  logic [7:0]       busTxData,
  input  logic [7:0]       engRxData,
  output logic [7:0]       engTxData,
  output logic [7:0]       busRxData,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output fifo_flags_t      flags
);

  byte_fifo #(.DEPTH(DEPTH)) uTxQ (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.txFlush),
    .push     (strobe.txPush),
    .pop      (strobe.txPop),
    .wdata    (busTxData),
    .rdata    (engTxData),
    .level    (txLevel),
    .full     (flags.txFull),
    .empty    (flags.txEmpty),
    .overrun  (flags.txOvr),
    .underrun (flags.txUnd)
  );

  byte_fifo #(.DEPTH(DEPTH)) uRxQ (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.rxFlush),
    .push     (strobe.rxPush),
    .pop      (strobe.rxPop),
    .wdata    (engRxData),
    .rdata    (busRxData),
    .level    (rxLevel),
    .full     (flags.rxFull),
    .empty    (flags.rxEmpty),
    .overrun  (flags.rxOvr),
    .underrun (flags.rxUnd)
  );

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = TRAIL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [STAT_W-1:0] ctrlWdata,
  input  logic              intEnWr,
  input  logic [STAT_W-1:0] intEnWdata,
  input  logic              intClrWr,
  input  logic [STAT_W-1:0] intClrWdata,
  input  logic              trailWr,
  input  logic [TRAIL_W-1:0] trailWdata,
  input  logic              busTxPush,
  input  logic              busRxPop,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              xferDone,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  fifo_flags_t       flags,
  output fifo_strobe_t      strobe,
  output logic [STAT_W-1:0] intStat,
  output logic              irq
);

  logic               txEn, rxEn;
  logic [TRIG_W-1:0]  txTrig, rxTrig;
  logic [TRAIL_W-1:0] trailField;
  logic [STAT_W-1:0]  intEn;
  logic [CNT_W-1:0]   idleCnt, idleLimit, idleInc;
  logic               rxRestart, trailFire;
  logic [STAT_W-1:0]  setVec, clrVec;

  // Strobes handed to the datapath, gated by the queue enables.
  always_comb begin
    strobe.txPush  = txEn && busTxPush;
    strobe.txPop   = txEn && engTxPop;
    strobe.txFlush = !txEn;
    strobe.rxPush  = rxEn && engRxPush;
    strobe.rxPop   = rxEn && busRxPop;
    strobe.rxFlush = !rxEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn       <= 1'b0;
      rxEn       <= 1'b0;
      txTrig     <= '0;
      rxTrig     <= '0;
      trailField <= '1;
      intEn      <= '0;
    end else begin
      if (ctrlWr) begin
        rxEn   <= ctrlWdata[CTRL_RX_EN];
        txEn   <= ctrlWdata[CTRL_TX_EN];
        rxTrig <= ctrlWdata[CTRL_RX_TRIG_LO +: TRIG_W];
        txTrig <= ctrlWdata[CTRL_TX_TRIG_LO +: TRIG_W];
      end
      if (trailWr) trailField <= trailWdata;
      if (intEnWr) intEn <= intEnWdata & IRQ_VALID;
    end
  end

  // Trailing-data timer: counts idle edges while received data waits.
  assign rxRestart = strobe.rxPush || strobe.rxPop;
  assign idleLimit = {1'b0, trailField} + 1'b1;
  assign idleInc   = idleCnt + 1'b1;
  assign trailFire = !rxRestart && !flags.rxEmpty &&
                     (idleCnt < idleLimit) && (idleInc == idleLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (rxRestart || flags.rxEmpty) begin
      idleCnt <= '0;
    end else if (idleCnt < idleLimit) begin
      idleCnt <= idleInc;
    end
  end

  always_comb begin
    setVec = '0;
    setVec[IRQ_TX_AE]  = TRIG_W'(txLevel) <= txTrig;
    setVec[IRQ_RX_AF]  = TRIG_W'(rxLevel) >= rxTrig;
    setVec[IRQ_TX_UND] = flags.txUnd;
    setVec[IRQ_TX_OVR] = flags.txOvr;
    setVec[IRQ_RX_UND] = flags.rxUnd;
    setVec[IRQ_RX_OVR] = flags.rxOvr;
    setVec[IRQ_TRAIL]  = trailFire;
    setVec[IRQ_XFER]   = xferDone;
    clrVec = intClrWr ? intClrWdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStat <= '0;
    else       intStat <= (intStat & ~clrVec) | setVec;
  end

  assign irq = |(intStat & intEn);

  assert_ovr_needs_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStat[IRQ_TX_OVR]) |-> $past(flags.txFull));

  assert_und_needs_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStat[IRQ_RX_UND]) |-> $past(flags.rxEmpty));

  assert_trail_needs_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStat[IRQ_TRAIL]) |-> $past(!flags.rxEmpty));

  assert_no_reserved_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intStat & ~IRQ_VALID) == '0);

endmodule

// File: rtl/dual_byte_fifo_irq.sv
module dual_byte_fifo_irq
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic [31:0] ctrlWdata,
  input  logic        intEnWr,
  input  logic [31:0] intEnWdata,
  input  logic        intClrWr,
  input  logic [31:0] intClrWdata,
  input  logic        trailWr,
  input  logic [3:0]  trailWdata,
  input  logic        busTxPush,
  input  logic [7:0]  busTxData,
  input  logic        busRxPop,
  output logic [7:0]  busRxData,
  input  logic        engTxPop,
  output logic [7:0]  engTxData,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  input  logic        xferDone,
  output logic [31:0] fifoStat,
  output logic [31:0] intStat,
  output logic        irq
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  fifo_strobe_t     strobe;
  fifo_flags_t      flags;
  logic [LVL_W-1:0] txLevel, rxLevel;

  fifo_irq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWr      (ctrlWr),
    .ctrlWdata   (ctrlWdata),
    .intEnWr     (intEnWr),
    .intEnWdata  (intEnWdata),
    .intClrWr    (intClrWr),
    .intClrWdata (intClrWdata),
    .trailWr     (trailWr),
    .trailWdata  (trailWdata),
    .busTxPush   (busTxPush),
    .busRxPop    (busRxPop),
    .engTxPop    (engTxPop),
    .engRxPush   (engRxPush),
    .xferDone    (xferDone),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .flags       (flags),
    .strobe      (strobe),
    .intStat     (intStat),
    .irq         (irq)
  );

  fifo_datapath #(.DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busTxData (busTxData),
    .engRxData (engRxData),
    .engTxData (engTxData),
    .busRxData (busRxData),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .flags     (flags)
  );

  always_comb begin
    fifoStat = '0;
    fifoStat[0 +: LVL_W]  = txLevel;
    fifoStat[7]           = flags.txFull;
    fifoStat[8]           = flags.txEmpty;
    fifoStat[16 +: LVL_W] = rxLevel;
    fifoStat[23]          = flags.rxFull;
    fifoStat[24]          = flags.rxEmpty;
  end

endmodule

// File: tb/sim_dual_byte_fifo_irq.sv
module sim_dual_byte_fifo_irq;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 0, intEnWr = 0, intClrWr = 0, trailWr = 0;
  logic [31:0] ctrlWdata = 0, intEnWdata = 0, intClrWdata = 0;
  logic [3:0]  trailWdata = 0;
  logic        busTxPush = 0, busRxPop = 0, engTxPop = 0, engRxPush = 0, xferDone = 0;
  logic [7:0]  busTxData = 0, engRxData = 0;
  logic [7:0]  busRxData, engTxData;
  logic [31:0] fifoStat, intStat;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dual_byte_fifo_irq #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN),
    .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .intEnWr(intEnWr), .intEnWdata(intEnWdata),
    .intClrWr(intClrWr), .intClrWdata(intClrWdata),
    .trailWr(trailWr), .trailWdata(trailWdata),
    .busTxPush(busTxPush), .busTxData(busTxData),
    .busRxPop(busRxPop), .busRxData(busRxData),
    .engTxPop(engTxPop), .engTxData(engTxData),
    .engRxPush(engRxPush), .engRxData(engRxData),
    .xferDone(xferDone),
    .fifoStat(fifoStat), .intStat(intStat), .irq(irq)
  );

  // Reference model state
  logic [7:0]  txQ[$];
  logic [7:0]  rxQ[$];
  logic [31:0] mStat, mIntEn, mSet;
  logic        mTxEn, mRxEn, mPopOk;
  int          mTxTrig, mRxTrig, mTrail, mIdle, txL, rxL;

  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      mStat = 0; mIntEn = 0; mTxEn = 0; mRxEn = 0;
      mTxTrig = 0; mRxTrig = 0; mTrail = 15; mIdle = 0;
    end else begin
      txL = txQ.size();
      rxL = rxQ.size();
      mSet = 0;
      if (txL <= mTxTrig) mSet[0] = 1;
      if (rxL >= mRxTrig) mSet[1] = 1;
      if (!mTxEn) txQ.delete();
      else begin
        mPopOk = engTxPop && txL > 0;
        if (engTxPop && txL == 0) mSet[2] = 1;
        if (busTxPush && txL == DEPTH && !mPopOk) mSet[3] = 1;
        if (mPopOk) void'(txQ.pop_front());
        if (busTxPush && (txL < DEPTH || mPopOk)) txQ.push_back(busTxData);
      end
      if (!mRxEn) rxQ.delete();
      else begin
        mPopOk = busRxPop && rxL > 0;
        if (busRxPop && rxL == 0) mSet[4] = 1;
        if (engRxPush && rxL == DEPTH && !mPopOk) mSet[5] = 1;
        if (mPopOk) void'(rxQ.pop_front());
        if (engRxPush && (rxL < DEPTH || mPopOk)) rxQ.push_back(engRxData);
      end
      if ((mRxEn && (engRxPush || busRxPop)) || rxL == 0) mIdle = 0;
      else if (mIdle < mTrail + 1) begin
        mIdle++;
        if (mIdle == mTrail + 1) mSet[6] = 1;
      end
      if (xferDone) mSet[9] = 1;
      if (intClrWr) mStat = mStat & ~intClrWdata;
      mStat = mStat | mSet;
      if (ctrlWr) begin
        mRxEn = ctrlWdata[0]; mTxEn = ctrlWdata[1];
        mRxTrig = int'(ctrlWdata[10:4]); mTxTrig = int'(ctrlWdata[22:16]);
      end
      if (trailWr) mTrail = int'(trailWdata);
      if (intEnWr) mIntEn = intEnWdata & 32'h0000_027F;
    end
  end

  function automatic logic [31:0] expFifoStat();
    logic [31:0] e = 0;
    e[6:0]   = 7'(txQ.size());
    e[7]     = txQ.size() == DEPTH;
    e[8]     = txQ.size() == 0;
    e[22:16] = 7'(rxQ.size());
    e[23]    = rxQ.size() == DEPTH;
    e[24]    = rxQ.size() == 0;
    return e;
  endfunction

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] eRx, eTx;
      eRx = (rxQ.size() > 0) ? rxQ[0] : 8'h00;
      eTx = (txQ.size() > 0) ? txQ[0] : 8'h00;
      vectors++;
      if (fifoStat !== expFifoStat()) begin
        miscompares++;
        $display("FAIL R2 fifoStat got %h expected %h", fifoStat, expFifoStat());
      end
      if (intStat !== mStat) begin
        miscompares++;
        $display("FAIL R8 intStat got %h expected %h", intStat, mStat);
      end
      if (irq !== |(mStat & mIntEn)) begin
        miscompares++;
        $display("FAIL R9 irq got %b expected %b", irq, |(mStat & mIntEn));
      end
      if (busRxData !== eRx) begin
        miscompares++;
        $display("FAIL R2 busRxData got %h expected %h", busRxData, eRx);
      end
      if (engTxData !== eTx) begin
        miscompares++;
        $display("FAIL R2 engTxData got %h expected %h", engTxData, eTx);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ctrlWr = 0; intEnWr = 0; intClrWr = 0; trailWr = 0;
    busTxPush = 0; busRxPop = 0; engTxPop = 0; engRxPush = 0; xferDone = 0;
  endtask

  task automatic wrCtrl(input logic [31:0] v);
    ctrlWr = 1; ctrlWdata = v; tick();
  endtask

  task automatic clrStat(input logic [31:0] v);
    intClrWr = 1; intClrWdata = v; tick();
  endtask

  task automatic txPush(input logic [7:0] d);
    busTxPush = 1; busTxData = d; tick();
  endtask

  task automatic rxPush(input logic [7:0] d);
    engRxPush = 1; engRxData = d; tick();
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 fifoStat", fifoStat, 32'h0100_0100);
    chk("R1 intStat", intStat, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rstN = 1;
    tick();
    wrCtrl(32'h0002_0043);          // both enabled, rx trig 4, tx trig 2
    clrStat(32'hFFFF_FFFF);

    // R2: ordering and packed level
    for (int i = 0; i < 5; i++) txPush(8'hA0 + 8'(i));
    chk("R2 tx level", fifoStat & 32'h1FF, 32'h5);
    for (int i = 0; i < 5; i++) begin
      chk("R2 tx order", {24'b0, engTxData}, 32'hA0 + i);
      engTxPop = 1; tick();
    end

    // R3: overrun on a full transmit queue
    for (int i = 0; i < 17; i++) txPush(8'hB0 + 8'(i));
    chk("R3 tx full level", fifoStat & 32'h1FF, 32'h90);
    chk("R3 overrun bit", {31'b0, intStat[3]}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      chk("R3 kept bytes", {24'b0, engTxData}, 32'hB0 + i);
      engTxPop = 1; tick();
    end
    chk("R3 dropped byte", fifoStat & 32'h1FF, 32'h100);

    // R4: underrun on empty receive queue
    clrStat(32'hFFFF_FFFF);
    chk("R4 pop data", {24'b0, busRxData}, 32'h0);
    busRxPop = 1; tick();
    chk("R4 underrun bit", {31'b0, intStat[4]}, 32'h1);

    // R5: transmit almost-empty threshold
    for (int i = 0; i < 3; i++) txPush(8'hC0 + 8'(i));
    clrStat(32'h1);
    chk("R5 above trigger", {31'b0, intStat[0]}, 32'h0);
    engTxPop = 1; tick();
    chk("R5 edge of pop", {31'b0, intStat[0]}, 32'h0);
    tick();
    chk("R5 at trigger", {31'b0, intStat[0]}, 32'h1);
    engTxPop = 1; tick();
    engTxPop = 1; tick();

    // R6: receive almost-full threshold
    clrStat(32'h2);
    for (int i = 0; i < 3; i++) rxPush(8'hD0 + 8'(i));
    tick();
    chk("R6 below trigger", {31'b0, intStat[1]}, 32'h0);
    rxPush(8'hD3);
    chk("R6 edge of push", {31'b0, intStat[1]}, 32'h0);
    tick();
    chk("R6 at trigger", {31'b0, intStat[1]}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 rx order", {24'b0, busRxData}, 32'hD0 + i);
      busRxPop = 1; tick();
    end

    // R7: trailing timer with field 3 -> four idle edges
    trailWr = 1; trailWdata = 4'd3; tick();
    intClrWr = 1; intClrWdata = 32'hFFFF_FFFF;
    rxPush(8'hE5);
    tick(); tick(); tick();
    chk("R7 before expiry", {31'b0, intStat[6]}, 32'h0);
    tick();
    chk("R7 at expiry", {31'b0, intStat[6]}, 32'h1);

    // R11: transfer event
    xferDone = 1; tick();
    chk("R11 xfer bit", {31'b0, intStat[9]}, 32'h1);

    // R8: selective write-one-to-clear
    clrStat(32'h40);
    chk("R8 cleared bit", {31'b0, intStat[6]}, 32'h0);
    chk("R8 kept bit", {31'b0, intStat[9]}, 32'h1);
    busRxPop = 1; tick();

    // R9: mask gating
    intEnWr = 1; intEnWdata = 32'h200; tick();
    chk("R9 irq enabled", {31'b0, irq}, 32'h1);
    clrStat(32'h200);
    chk("R9 irq masked rest", {31'b0, irq}, 32'h0);
    intEnWr = 1; intEnWdata = 32'h0; tick();

    // R10: disabled transmit queue ignores pushes
    wrCtrl(32'h0002_0041);
    clrStat(32'hFFFF_FFFF);
    txPush(8'h11);
    txPush(8'h12);
    chk("R10 tx stays empty", fifoStat & 32'h1FF, 32'h100);
    chk("R10 no overrun", {31'b0, intStat[3]}, 32'h0);
    wrCtrl(32'h0002_0043);

    // R12: push and pop together on a full queue
    for (int i = 0; i < 16; i++) txPush(8'h40 + 8'(i));
    clrStat(32'hFFFF_FFFF);
    busTxPush = 1; busTxData = 8'hEF; engTxPop = 1; tick();
    chk("R12 level kept", fifoStat & 32'h1FF, 32'h90);
    chk("R12 no overrun", {31'b0, intStat[3]}, 32'h0);
    chk("R12 new head", {24'b0, engTxData}, 32'h41);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk("R12 last byte", {24'b0, engTxData}, 32'hEF);
      engTxPop = 1; tick();
    end
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule